// File: doc/BRIEF.md
# Receive Packet Store with Descriptor Slots

This block holds received packets between an upstream receive filter and a host. The filter delivers one byte per beat with start-of-packet and end-of-packet markers; on the end beat it also supplies the packet type and its error flags. Bytes go into a circular byte buffer at a tail pointer. Each packet is tracked by one entry in a small table of descriptor slots. An entry holds a valid bit, a completion bit, the start address, the length and an info field. Slots are handed out in strict rotation, so the valid slots always form one contiguous run. When the next slot in the rotation is still valid, every slot is in use and the arriving packet is dropped.

The host reads the oldest complete packet one byte per request. A head pointer walks through the packet as it is read. When the host has read the whole packet it issues release. To abandon a packet part-way it issues skip, which moves the head past the unread bytes. Either command frees the slot and makes the next slot current. The current descriptor is always presented on dedicated outputs, and any slot can be inspected through an index port. If a packet arrives while the byte store is completely occupied, the packet is truncated. Its bytes are reclaimed and its slot is handed back without becoming readable.

The write side is a three-state machine. W_IDLE waits for a start beat. A start beat with a free slot and free space claims the slot and goes to W_STORE, or commits at once and stays in W_IDLE if the start beat also ends the packet. A start beat that finds no free slot, or that truncates, goes to W_DROP, or stays in W_IDLE if it is also the end beat. W_STORE stores bytes and returns to W_IDLE on the end beat; on overrun it truncates and goes to W_DROP, or to W_IDLE if that beat ends the packet. W_DROP discards beats until the end beat and then returns to W_IDLE.

Top module: `rx_pkt_store`

## Requirements
- R1: Bytes of stored packets occupy consecutive buffer addresses starting at the tail, wrapping modulo the buffer depth. A packet's start address equals the end address of the previous stored packet. Reading returns the bytes in arrival order, including across the wrap point.
- R2: Each stored packet claims the next slot in rotation (0, 1, ... SLOTS-1, 0). The claimed slot reads valid, and its address field holds the packet's start address.
- R3: A packet whose start beat finds all slots valid is discarded completely. It gives a one-cycle irq_full pulse and no irq_rx, writes no byte and leaves the tail unchanged.
- R4: irq_rx pulses for exactly one cycle, in the cycle after the clock edge that takes the end beat. A packet becomes current (cur_valid = 1) only from that same edge.
- R5: A slot's length field holds the number of stored bytes. Its info field uses this encoding: bits [1:0] are the type (0 unicast, 1 multicast, 2 broadcast), bit 2 is the CRC error flag and bit 3 is the incomplete flag. The upstream type and flags are copied from in_flags on the end beat.
- R6: A rd_req on a current packet with unread bytes returns the byte at the head on rd_data in the following cycle and advances the head by one.
- R7: cmd_release is accepted only when a current packet exists and all its bytes have been read. It then clears that slot's valid bit and advances cur_slot by one in rotation. Otherwise it has no effect.
- R8: cmd_skip on a current packet clears that slot's valid bit, sets the head to start address plus length modulo the depth, and advances cur_slot. The next packet is then read from its first byte.
- R9: cur_slot, cur_addr, cur_len and cur_info mirror the current slot. dbg_valid, dbg_addr, dbg_len and dbg_info show the slot selected by dbg_idx combinationally.
- R10: A byte that arrives while the buffer holds DEPTH bytes truncates its packet. The slot is left invalid with the incomplete bit set and the length set to the bytes stored so far. The tail returns to the packet's start, no irq_rx is given, and the rest of the packet is dropped.
- R11: A rd_req when no current packet exists, or when the current packet is fully read, returns 0 on rd_data and leaves the head unchanged. It also sets the sticky underflow flag, which stays set until reset.
- R12: After reset all slots are invalid, cur_slot is 0, head and tail are 0, and rd_data, irq_rx, irq_full and underflow are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Upstream byte beat present |
| in_data | input | 8 | Upstream byte |
| in_sop | input | 1 | Beat is first byte of a packet |
| in_eop | input | 1 | Beat is last byte of a packet |
| in_flags | input | 4 | Type and error flags, sampled on the end beat (R5 encoding) |
| rd_req | input | 1 | Host requests one byte of the current packet |
| rd_data | output | 8 | Byte returned one cycle after rd_req |
| cmd_release | input | 1 | Free the fully read current packet |
| cmd_skip | input | 1 | Drop the rest of the current packet |
| cur_slot | output | $clog2(SLOTS) | Index of the current slot |
| cur_valid | output | 1 | A complete packet is current |
| cur_addr | output | ADDR_W | Start address of the current packet |
| cur_len | output | ADDR_W+1 | Length of the current packet |
| cur_info | output | 4 | Info field of the current packet |
| dbg_idx | input | $clog2(SLOTS) | Slot selected for inspection |
| dbg_valid | output | 1 | Valid bit of the selected slot |
| dbg_addr | output | ADDR_W | Address field of the selected slot |
| dbg_len | output | ADDR_W+1 | Length field of the selected slot |
| dbg_info | output | 4 | Info field of the selected slot |
| irq_rx | output | 1 | One-cycle pulse when a packet is stored |
| irq_full | output | 1 | One-cycle pulse when a packet is dropped for lack of a slot |
| underflow | output | 1 | Sticky flag for reads with nothing to return |

## Verification
The hardest case to reach is the mid-packet overrun, because the buffer must already hold almost DEPTH bytes of unread data when a new packet arrives. The bench builds the block with a 64-byte buffer and first stores one 40-byte packet without reading it. It then sends a 30-byte packet, so the 25th byte finds the store full. The bench checks that the truncated slot is left invalid with 24 bytes recorded, and that the next packet starts at the reclaimed address. Filling all eight slots with unread packets before a ninth start beat sets up the no-free-slot case in the same way.

// File: rtl/rxps_pkg.sv
package rxps_pkg;

    // info field layout shared by writer, slot table and host view
    localparam int INFO_W   = 4;
    localparam int INFO_CRC = 2;
    localparam int INFO_INC = 3;

    typedef enum logic [1:0] {
        W_IDLE  = 2'd0,
        W_STORE = 2'd1,
        W_DROP  = 2'd2
    } wr_state_e;

endpackage

// File: rtl/rxps_byte_ram.sv
module rxps_byte_ram #(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [7:0]    wd,
    input  logic          re,
    input  logic          rz,
    input  logic [AW-1:0] ra,
    output logic [7:0]    q
);

    localparam int DEPTH = 1 << AW;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[wa] <= wd;
        end
    end

    // registered read port; a refused request returns zero
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= 8'd0;
        end else if (re) begin
            q <= mem[ra];
        end else if (rz) begin
            q <= 8'd0;
        end
    end

endmodule

// File: rtl/rxps_slot_table.sv
module rxps_slot_table
    import rxps_pkg::*;
#(
    parameter int SLOTS = 8,
    parameter int AW    = 12,
    parameter int SW    = $clog2(SLOTS),
    parameter int LW    = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              claim,
    input  logic              commit,
    input  logic              trunc,
    input  logic [SW-1:0]     w_idx,
    input  logic [AW-1:0]     w_addr,
    input  logic [LW-1:0]     w_len,
    input  logic [INFO_W-1:0] w_info,
    input  logic              clr,
    input  logic [SW-1:0]     c_idx,
    input  logic [SW-1:0]     d_idx,
    output logic              w_busy,
    output logic              c_ready,
    output logic [AW-1:0]     c_addr,
    output logic [LW-1:0]     c_len,
    output logic [INFO_W-1:0] c_info,
    output logic              d_valid,
    output logic [AW-1:0]     d_addr,
    output logic [LW-1:0]     d_len,
    output logic [INFO_W-1:0] d_info
);

    logic              s_valid [SLOTS];
    logic              s_done  [SLOTS];
    logic [AW-1:0]     s_addr  [SLOTS];
    logic [LW-1:0]     s_len   [SLOTS];
    logic [INFO_W-1:0] s_info  [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        logic hit_w;
        logic hit_c;
        assign hit_w = (w_idx == SW'(g));
        assign hit_c = (c_idx == SW'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s_valid[g] <= 1'b0;
                s_done[g]  <= 1'b0;
                s_addr[g]  <= '0;
                s_len[g]   <= '0;
                s_info[g]  <= '0;
            end else begin
                if (claim && hit_w) begin
                    s_valid[g] <= 1'b1;
                    s_done[g]  <= 1'b0;
                    s_addr[g]  <= w_addr;
                end
                if (commit && hit_w) begin
                    s_done[g] <= 1'b1;
                    s_len[g]  <= w_len;
                    s_info[g] <= w_info;
                end
                if (trunc && hit_w) begin
                    s_valid[g] <= 1'b0;
                    s_done[g]  <= 1'b0;
                    s_addr[g]  <= w_addr;
                    s_len[g]   <= w_len;
                    s_info[g]  <= w_info;
                end
                if (clr && hit_c) begin
                    s_valid[g] <= 1'b0;
                    s_done[g]  <= 1'b0;
                end
            end
        end
    end

    assign w_busy  = s_valid[w_idx];
    assign c_ready = s_valid[c_idx] && s_done[c_idx];
    assign c_addr  = s_addr[c_idx];
    assign c_len   = s_len[c_idx];
    assign c_info  = s_info[c_idx];
    assign d_valid = s_valid[d_idx];
    assign d_addr  = s_addr[d_idx];
    assign d_len   = s_len[d_idx];
    assign d_info  = s_info[d_idx];

    AST_CLAIM_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        claim |-> !s_valid[w_idx]) else $error("claim of a busy slot"); // R2

    AST_COMMIT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (s_valid[$past(w_idx)] && s_done[$past(w_idx)])) else $error("commit not visible"); // R4

endmodule

// File: rtl/rxps_wr_fsm.sv
module rxps_wr_fsm
    import rxps_pkg::*;
#(
    parameter int SLOTS = 8,
    parameter int AW    = 12,
    parameter int SW    = $clog2(SLOTS),
    parameter int LW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_sop,
    input  logic          in_eop,
    input  logic          slot_busy,
    input  logic          buf_full,
    output logic          claim,
    output logic          commit,
    output logic          trunc,
    output logic          we,
    output logic [AW-1:0] tail,
    output logic [AW-1:0] start_addr,
    output logic [LW-1:0] plen,
    output logic [SW-1:0] wslot,
    output logic          irq_rx,
    output logic          irq_full
);

    localparam logic [SW-1:0] LAST_SLOT = SW'(SLOTS - 1);

    wr_state_e     state_q;
    wr_state_e     state_d;
    logic [AW-1:0] start_q;
    logic [LW-1:0] cnt_q;
    logic          full_evt;

    assign start_addr = (state_q == W_IDLE) ? tail : start_q;
    assign plen       = (state_q == W_IDLE) ? '0   : cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= W_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        claim    = 1'b0;
        commit   = 1'b0;
        trunc    = 1'b0;
        we       = 1'b0;
        full_evt = 1'b0;
        unique case (state_q)
            W_IDLE: begin
                if (in_valid && in_sop) begin
                    if (slot_busy) begin
                        full_evt = 1'b1;
                        state_d  = in_eop ? W_IDLE : W_DROP;
                    end else if (buf_full) begin
                        trunc   = 1'b1;
                        state_d = in_eop ? W_IDLE : W_DROP;
                    end else begin
                        claim   = 1'b1;
                        we      = 1'b1;
                        commit  = in_eop;
                        state_d = in_eop ? W_IDLE : W_STORE;
                    end
                end
            end
            W_STORE: begin
                if (in_valid) begin
                    if (buf_full) begin
                        trunc   = 1'b1;
                        state_d = in_eop ? W_IDLE : W_DROP;
                    end else begin
                        we      = 1'b1;
                        commit  = in_eop;
                        state_d = in_eop ? W_IDLE : W_STORE;
                    end
                end
            end
            W_DROP: begin
                if (in_valid && in_eop) begin
                    state_d = W_IDLE;
                end
            end
            default: state_d = W_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tail     <= '0;
            start_q  <= '0;
            cnt_q    <= '0;
            wslot    <= '0;
            irq_rx   <= 1'b0;
            irq_full <= 1'b0;
        end else begin
            if (we) begin
                tail  <= tail + 1'b1;
                cnt_q <= plen + 1'b1;
            end else if (trunc) begin
                tail <= start_addr;
            end
            if (claim) begin
                start_q <= tail;
            end
            if (commit) begin
                wslot <= (wslot == LAST_SLOT) ? '0 : wslot + 1'b1;
            end
            irq_rx   <= commit;
            irq_full <= full_evt;
        end
    end

    AST_TAIL_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
        trunc |=> (tail == $past(start_addr))) else $error("tail not reclaimed"); // R10

    AST_DROP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == W_DROP) |=> $stable(tail)) else $error("bytes stored while dropping"); // R3

endmodule

// File: rtl/rx_pkt_store.sv
module rx_pkt_store
    import rxps_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int SLOTS  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [7:0]               in_data,
    input  logic                     in_sop,
    input  logic                     in_eop,
    input  logic [INFO_W-1:0]        in_flags,
    input  logic                     rd_req,
    output logic [7:0]               rd_data,
    input  logic                     cmd_release,
    input  logic                     cmd_skip,
    output logic [$clog2(SLOTS)-1:0] cur_slot,
    output logic                     cur_valid,
    output logic [ADDR_W-1:0]        cur_addr,
    output logic [ADDR_W:0]          cur_len,
    output logic [INFO_W-1:0]        cur_info,
    input  logic [$clog2(SLOTS)-1:0] dbg_idx,
    output logic                     dbg_valid,
    output logic [ADDR_W-1:0]        dbg_addr,
    output logic [ADDR_W:0]          dbg_len,
    output logic [INFO_W-1:0]        dbg_info,
    output logic                     irq_rx,
    output logic                     irq_full,
    output logic                     underflow
);

    localparam int AW = ADDR_W;
    localparam int LW = ADDR_W + 1;
    localparam int SW = $clog2(SLOTS);
    localparam logic [SW-1:0] LAST_SLOT = SW'(SLOTS - 1);
    localparam logic [AW:0]   FILL_MAX  = {1'b1, {AW{1'b0}}};

    logic              claim, commit, trunc, we, slot_busy;
    logic [AW-1:0]     tail, start_addr, head;
    logic [LW-1:0]     plen, tbl_len, rd_cnt;
    logic [SW-1:0]     wslot;
    logic [INFO_W-1:0] tbl_info;
    logic [AW:0]       fill, fill_nxt;
    logic              skip_ok, rel_ok, cmd_any, rd_ok, rd_zero;

    rxps_wr_fsm #(.SLOTS(SLOTS), .AW(AW), .SW(SW), .LW(LW)) u_wr (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_sop     (in_sop),
        .in_eop     (in_eop),
        .slot_busy  (slot_busy),
        .buf_full   (fill == FILL_MAX),
        .claim      (claim),
        .commit     (commit),
        .trunc      (trunc),
        .we         (we),
        .tail       (tail),
        .start_addr (start_addr),
        .plen       (plen),
        .wslot      (wslot),
        .irq_rx     (irq_rx),
        .irq_full   (irq_full)
    );

    // commit records the byte of this beat; truncation records what was kept
    assign tbl_len  = trunc ? plen : plen + 1'b1;
    assign tbl_info = trunc ? INFO_W'(1 << INFO_INC) : in_flags;

    rxps_slot_table #(.SLOTS(SLOTS), .AW(AW), .SW(SW), .LW(LW)) u_tbl (
        .clk     (clk),
        .rst_n   (rst_n),
        .claim   (claim),
        .commit  (commit),
        .trunc   (trunc),
        .w_idx   (wslot),
        .w_addr  (start_addr),
        .w_len   (tbl_len),
        .w_info  (tbl_info),
        .clr     (cmd_any),
        .c_idx   (cur_slot),
        .d_idx   (dbg_idx),
        .w_busy  (slot_busy),
        .c_ready (cur_valid),
        .c_addr  (cur_addr),
        .c_len   (cur_len),
        .c_info  (cur_info),
        .d_valid (dbg_valid),
        .d_addr  (dbg_addr),
        .d_len   (dbg_len),
        .d_info  (dbg_info)
    );

    rxps_byte_ram #(.AW(AW)) u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (we),
        .wa    (tail),
        .wd    (in_data),
        .re    (rd_ok),
        .rz    (rd_zero),
        .ra    (head),
        .q     (rd_data)
    );

    // host side: an accepted command wins over a read in the same cycle
    always_comb begin
        skip_ok = cmd_skip && cur_valid;
        rel_ok  = cmd_release && !cmd_skip && cur_valid && (rd_cnt == cur_len);
        cmd_any = skip_ok || rel_ok;
        rd_ok   = rd_req && !cmd_any && cur_valid && (rd_cnt < cur_len);
        rd_zero = rd_req && !cmd_any && !rd_ok;
        fill_nxt = fill + (AW+1)'(we) - (AW+1)'(rd_ok)
                 - (skip_ok ? (cur_len - rd_cnt) : '0)
                 - (trunc ? plen : '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head      <= '0;
            rd_cnt    <= '0;
            cur_slot  <= '0;
            fill      <= '0;
            underflow <= 1'b0;
        end else begin
            fill <= fill_nxt;
            if (skip_ok) begin
                head <= cur_addr + cur_len[AW-1:0];
            end else if (rd_ok) begin
                head <= head + 1'b1;
            end
            if (cmd_any) begin
                rd_cnt   <= '0;
                cur_slot <= (cur_slot == LAST_SLOT) ? '0 : cur_slot + 1'b1;
            end else if (rd_ok) begin
                rd_cnt <= rd_cnt + 1'b1;
            end
            if (rd_zero) begin
                underflow <= 1'b1;
            end
        end
    end

    AST_NO_OVERFILL: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= FILL_MAX) else $error("occupancy above depth"); // R10

    AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !cur_valid) |=> ($stable(head) && rd_data == 8'd0 && underflow)) else $error("empty read moved head"); // R11

    AST_UF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> underflow) else $error("underflow cleared"); // R11

    AST_IRQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({irq_rx, irq_full})) else $error("both interrupts"); // R3

    AST_SKIP_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        skip_ok |=> (head == $past(cur_addr) + $past(cur_len[AW-1:0]))) else $error("skip head wrong"); // R8

endmodule

// File: tb/test_rx_pkt_store.sv
module test_rx_pkt_store;

    localparam int CLK_PERIOD = 10;
    localparam int AW    = 6;
    localparam int LW    = AW + 1;
    localparam int SLOTS = 8;
    localparam int SW    = 3;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [7:0]    in_data = 8'd0;
    logic          in_sop = 1'b0;
    logic          in_eop = 1'b0;
    logic [3:0]    in_flags = 4'd0;
    logic          rd_req = 1'b0;
    logic [7:0]    rd_data;
    logic          cmd_release = 1'b0;
    logic          cmd_skip = 1'b0;
    logic [SW-1:0] cur_slot;
    logic          cur_valid;
    logic [AW-1:0] cur_addr;
    logic [LW-1:0] cur_len;
    logic [3:0]    cur_info;
    logic [SW-1:0] dbg_idx = '0;
    logic          dbg_valid;
    logic [AW-1:0] dbg_addr;
    logic [LW-1:0] dbg_len;
    logic [3:0]    dbg_info;
    logic          irq_rx, irq_full, underflow;

    int n_checks = 0;
    int n_errors = 0;
    int exp_tail = 0;
    int exp_slot = 0;

    rx_pkt_store #(.ADDR_W(AW), .SLOTS(SLOTS)) i_rx_pkt_store (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_sop(in_sop), .in_eop(in_eop), .in_flags(in_flags),
        .rd_req(rd_req), .rd_data(rd_data), .cmd_release(cmd_release),
        .cmd_skip(cmd_skip), .cur_slot(cur_slot), .cur_valid(cur_valid),
        .cur_addr(cur_addr), .cur_len(cur_len), .cur_info(cur_info),
        .dbg_idx(dbg_idx), .dbg_valid(dbg_valid), .dbg_addr(dbg_addr),
        .dbg_len(dbg_len), .dbg_info(dbg_info), .irq_rx(irq_rx),
        .irq_full(irq_full), .underflow(underflow)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] pat(int seed, int i);
        return 8'((seed * 7 + i * 13 + 5) & 255);
    endfunction

    function automatic logic [3:0] flg(int k);
        return 4'((k % 3) | ((k & 1) << 2));
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic send(int len, int seed, logic [3:0] flags,
                        output bit saw_rx, output bit saw_full, output bit pre_valid);
        saw_rx = 0; saw_full = 0; pre_valid = 0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            saw_rx   |= irq_rx;
            saw_full |= irq_full;
            if (i == len - 1) pre_valid = cur_valid;
            in_valid = 1'b1;
            in_data  = pat(seed, i);
            in_sop   = (i == 0);
            in_eop   = (i == len - 1);
            in_flags = (i == len - 1) ? flags : 4'd0;
        end
        @(negedge clk);
        saw_rx   |= irq_rx;
        saw_full |= irq_full;
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_flags = 4'd0;
    endtask

    task automatic rd(output logic [7:0] b);
        @(negedge clk); rd_req = 1'b1;
        @(negedge clk); rd_req = 1'b0;
        b = rd_data;
    endtask

    task automatic cmd(bit rel, bit skp);
        @(negedge clk); cmd_release = rel; cmd_skip = skp;
        @(negedge clk); cmd_release = 1'b0; cmd_skip = 1'b0;
    endtask

    task automatic read_pkt(int len, int seed, string tag);
        logic [7:0] b;
        for (int i = 0; i < len; i++) begin
            rd(b);
            chk(tag, b, pat(seed, i));
        end
    endtask

    task automatic peek(int idx);
        dbg_idx = SW'(idx);
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        bit rx, full, pre;
        logic [7:0] b;
        int a_start, b_slot, b_start;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset state
        chk("R12 cur_valid", cur_valid, 0);
        chk("R12 cur_slot", cur_slot, 0);
        chk("R12 rd_data", rd_data, 0);
        chk("R12 irq_rx", irq_rx, 0);
        chk("R12 irq_full", irq_full, 0);
        chk("R12 underflow", underflow, 0);
        for (int s = 0; s < SLOTS; s++) begin
            peek(s);
            chk("R12 slot valid", dbg_valid, 0);
        end

        // R11 read with nothing stored
        rd(b);
        chk("R11 empty read data", b, 0);
        chk("R11 underflow set", underflow, 1);

        // R2 R4 R5 R9: fill all slots, lengths 1..8
        for (int k = 0; k < SLOTS; k++) begin
            send(k + 1, k, flg(k), rx, full, pre);
            chk("R4 irq_rx", rx, 1);
            chk("R3 no irq_full", full, 0);
            if (k == 0) chk("R4 not current before end", pre, 0);
        end
        for (int s = 0; s < SLOTS; s++) begin
            peek(s);
            chk("R2 slot valid", dbg_valid, 1);
            chk("R2 slot addr", dbg_addr, (s * (s + 1) / 2) % DEPTH);
            chk("R5 slot len", dbg_len, s + 1);
            chk("R5 slot info", dbg_info, flg(s));
        end
        exp_tail = 36;
        chk("R9 cur_slot", cur_slot, 0);
        chk("R9 cur_addr", cur_addr, 0);
        chk("R9 cur_len", cur_len, 1);
        chk("R9 cur_info", cur_info, flg(0));

        // R3 ninth packet dropped
        send(3, 99, 4'd0, rx, full, pre);
        chk("R3 irq_full", full, 1);
        chk("R3 no irq_rx", rx, 0);
        peek(0);
        chk("R3 slot0 untouched", dbg_len, 1);

        // R6 R7 read and release packet 0
        read_pkt(1, 0, "R6 pkt0 data");
        cmd(1, 0);
        chk("R7 release advances", cur_slot, 1);
        cmd(1, 0);
        chk("R7 early release ignored", cur_slot, 1);
        chk("R7 still current", cur_valid, 1);

        // R8 skip part-read packet 1
        read_pkt(1, 1, "R6 pkt1 first byte");
        cmd(0, 1);
        chk("R8 skip advances", cur_slot, 2);
        peek(1);
        chk("R8 skipped slot freed", dbg_valid, 0);
        chk("R8 next addr", cur_addr, 3);
        read_pkt(3, 2, "R8 head after skip");
        rd(b);
        chk("R11 read past end", b, 0);
        cmd(1, 0);
        chk("R7 release after full read", cur_slot, 3);
        for (int s = 3; s < SLOTS; s++) begin
            read_pkt(s + 1, s, "R1 stored data");
            cmd(1, 0);
        end
        chk("R7 wrapped to slot 0", cur_slot, 0);
        chk("R7 none current", cur_valid, 0);

        // R1 R2 sweep of lengths across several wraps
        for (int L = 1; L <= 30; L++) begin
            send(L, 100 + L, flg(L), rx, full, pre);
            chk("R4 sweep irq_rx", rx, 1);
            chk("R1 sweep addr", cur_addr, exp_tail);
            chk("R2 sweep slot", cur_slot, exp_slot);
            chk("R5 sweep len", cur_len, L);
            read_pkt(L, 100 + L, "R1 sweep data");
            cmd(1, 0);
            exp_tail = (exp_tail + L) % DEPTH;
            exp_slot = (exp_slot + 1) % SLOTS;
        end

        // R10 boundary: exactly DEPTH bytes fit
        send(DEPTH, 7, 4'd2, rx, full, pre);
        chk("R10 full-size stored", rx, 1);
        chk("R5 full-size len", cur_len, DEPTH);
        read_pkt(DEPTH, 7, "R1 full-size data");
        cmd(1, 0);
        exp_slot = (exp_slot + 1) % SLOTS;

        // R10 overrun mid-packet
        a_start = exp_tail;
        send(40, 11, 4'd1, rx, full, pre);
        chk("R4 A stored", rx, 1);
        b_slot  = (exp_slot + 1) % SLOTS;
        b_start = (a_start + 40) % DEPTH;
        send(30, 12, 4'd0, rx, full, pre);
        chk("R10 no irq_rx", rx, 0);
        peek(b_slot);
        chk("R10 slot invalid", dbg_valid, 0);
        chk("R10 kept length", dbg_len, DEPTH - 40);
        chk("R10 incomplete bit", dbg_info[3], 1);
        chk("R10 A still current", cur_slot, exp_slot);
        send(5, 13, 4'd2, rx, full, pre);
        chk("R10 C stored", rx, 1);
        peek(b_slot);
        chk("R10 C reuses slot", dbg_valid, 1);
        chk("R10 C at reclaimed addr", dbg_addr, b_start);
        read_pkt(40, 11, "R10 A data");
        cmd(1, 0);
        chk("R10 C current", cur_slot, b_slot);
        read_pkt(5, 13, "R10 C data");
        cmd(1, 0);
        chk("R11 underflow sticky", underflow, 1);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule